// File: doc/BRIEF.md
# Fraction-Saving Second-Order IIR Section

This block is one second-order recursive filter section in fixed point. It runs one multiply-accumulate per clock through a single multiplier. Samples are signed integers and coefficients are signed Q2.26 values. A filter result is the high part of a wide accumulator, cut by plain truncation toward minus infinity. The fractional bits that truncation drops are kept in a residue register. At the next sample they are loaded back into the accumulator, zero-extended, before the first product is added. Carrying the residue forward this way shapes the rounding error with a zero at DC. It also stops the section from locking onto a small nonzero value once the input goes silent. The cost is one extra register and no extra multiply cycles.

Samples enter and results leave on valid/ready streams. Only one sample is in flight at a time. `in_ready` is high while the section is idle. It is also high while a finished result is being taken in the same cycle (`out_valid` and `out_ready` both high), so a downstream that never stalls gets one result every 6 clocks. `in_valid` may be held high for as long as the producer wants. A transfer happens only on an edge where both signals are high. When `out_ready` is low, the result stays on `out_data` unchanged and no new sample is accepted. The five coefficients are written through a plain write port. A write changes the register on the next edge, so the software should only write while the section is idle.

Top module: `biquad_fs`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0. All coefficients, delay states and the residue are zero, so the first sample processed after reset gives 0.
- R2: A sample is taken on a rising edge where `in_valid` and `in_ready` are both 1. From that edge until its result is taken, `in_ready` is 0, except in the cycle where `out_valid` and `out_ready` are both 1.
- R3: `out_valid` goes to 1 right after the fifth rising edge that follows the accepting edge. With `in_valid` and `out_ready` held at 1, accepted samples are exactly 6 clocks apart.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change. The result is taken on the edge where `out_ready` is 1.
- R5: The accumulator value is A = r + b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]. Here coefficients are Q2.26, samples are integers, y are the stored (clamped) outputs, and r is the residue. The output is floor(A / 2^26). Coefficient select codes are 0=b0, 1=b1, 2=b2, 3=a1, 4=a2.
- R6: The residue saved at each result is A mod 2^26, which is always non-negative. It is added to the next sample's accumulation. For example, with b0 = 0.5 only, the inputs 1, 1, −1, −1 give the outputs 0, 1, −1, 0.
- R7: When floor(A / 2^26) is above 2^27−1, the stored output is 2^27−1. When it is below −2^27, the stored output is −2^27.
- R8: With b0 = 1 and a1 = −0.5, a nonzero input followed by zeros brings the output to exactly 0 within a few samples, and it stays 0.
- R9: A coefficient write with select code 5, 6 or 7 changes no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Section can take a sample |
| in_data | input | DATA_W (28) | Signed input sample |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | DATA_W (28) | Signed, clamped result |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 3 | Coefficient select (0..4 used) |
| coef_wdata | input | COEF_W (28) | Signed Q2.26 coefficient value |

## Verification
A lost or stale residue does not show at once. It appears as an off-by-one LSB on the sample after an odd fractional remainder. Under zero input it shows as an output stuck at −1 instead of decaying to 0, so the residue and settle sequences compare every output against exact hand-derived values. A delay-line slip or a sign error in the feedback corrupts the next one or two outputs, and the streaming runs compare every result with a bench model. A schedule error moves the `out_valid` edge or the 6-clock spacing, and the bench checks both on the exact cycle.

// File: rtl/biquad_fs_pkg.sv
package biquad_fs_pkg;

  localparam int NUM_TAPS  = 5;
  localparam int TAP_SEL_W = 3;

  // MAC order inside one sample; the encoding doubles as the write-port select code
  typedef enum logic [TAP_SEL_W-1:0] {
    TAP_B0 = 3'd0,
    TAP_B1 = 3'd1,
    TAP_B2 = 3'd2,
    TAP_A1 = 3'd3,
    TAP_A2 = 3'd4
  } tap_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_MAC  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_t;

endpackage

// File: rtl/biquad_fs_coef.sv
module biquad_fs_coef
  import biquad_fs_pkg::*;
#(
  parameter int COEF_W = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [TAP_SEL_W-1:0] wr_sel,
  input  logic [COEF_W-1:0]    wr_data,
  input  tap_t                 rd_tap,
  output logic [COEF_W-1:0]    rd_coef
);

  logic [COEF_W-1:0]          coef_q [NUM_TAPS];
  logic [NUM_TAPS*COEF_W-1:0] coef_flat;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_coef
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        coef_q[i] <= '0;
      end else if (wr_en && (wr_sel == TAP_SEL_W'(i))) begin
        coef_q[i] <= wr_data;
      end
    end
    assign coef_flat[i*COEF_W +: COEF_W] = coef_q[i];
  end

  always_comb begin
    case (rd_tap)
      TAP_B0:  rd_coef = coef_q[0];
      TAP_B1:  rd_coef = coef_q[1];
      TAP_B2:  rd_coef = coef_q[2];
      TAP_A1:  rd_coef = coef_q[3];
      TAP_A2:  rd_coef = coef_q[4];
      default: rd_coef = '0;
    endcase
  end

  // R9: codes beyond the last tap leave every coefficient untouched
  assert_unused_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel >= TAP_SEL_W'(NUM_TAPS))) |=> $stable(coef_flat));

endmodule

// File: rtl/biquad_fs_seq.sv
module biquad_fs_seq
  import biquad_fs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load_en,
  output logic mac_en,
  output logic store_en,
  output tap_t tap
);

  seq_state_t state_q;
  tap_t       tap_q;

  always_comb begin
    in_ready  = (state_q == SEQ_IDLE) || ((state_q == SEQ_HOLD) && out_ready);
    out_valid = (state_q == SEQ_HOLD);
    load_en   = in_valid && in_ready;
    mac_en    = (state_q == SEQ_MAC);
    store_en  = mac_en && (tap_q == TAP_A2);
    tap       = tap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tap_q   <= TAP_B0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (load_en) begin
            state_q <= SEQ_MAC;
            tap_q   <= TAP_B0;
          end
        end
        SEQ_MAC: begin
          if (tap_q == TAP_A2) begin
            state_q <= SEQ_HOLD;
          end else begin
            tap_q <= tap_t'(tap_q + 3'd1);
          end
        end
        SEQ_HOLD: begin
          if (load_en) begin
            state_q <= SEQ_MAC;
            tap_q   <= TAP_B0;
          end else if (out_ready) begin
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R3: the MAC walk visits the taps in order, one per clock
  assert_tap_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && (tap_q != TAP_A2)) |=> (mac_en && (tap_q == tap_t'($past(tap_q) + 3'd1))));

  // R3: the last MAC hands over straight to a valid result
  assert_store_to_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |=> out_valid);

endmodule

// File: rtl/biquad_fs_dp.sv
module biquad_fs_dp
  import biquad_fs_pkg::*;
#(
  parameter int DATA_W    = 28,
  parameter int COEF_W    = 28,
  parameter int COEF_FRAC = 26,
  parameter int GUARD_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              mac_en,
  input  logic              store_en,
  input  tap_t              tap,
  input  logic [DATA_W-1:0] in_data,
  input  logic [COEF_W-1:0] coef,
  output logic [DATA_W-1:0] out_data
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + GUARD_W;
  localparam int HI_W   = ACC_W - COEF_FRAC;

  localparam logic signed [HI_W-1:0] HI_MAX =
    {{(HI_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [HI_W-1:0] HI_MIN =
    {{(HI_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] x0_q, x1_q, x2_q, y1_q, y2_q, yout_q;
  logic        [COEF_FRAC-1:0] res_q;
  logic signed [ACC_W-1:0]  acc_q;

  logic signed [DATA_W-1:0] operand;
  logic signed [COEF_W-1:0] coef_s;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext, term, sum;
  logic signed [HI_W-1:0]   sum_hi;
  logic        [COEF_FRAC-1:0] sum_lo;
  logic signed [DATA_W-1:0] y_sat;
  logic                     is_fb;

  always_comb begin
    case (tap)
      TAP_B0:  operand = x0_q;
      TAP_B1:  operand = x1_q;
      TAP_B2:  operand = x2_q;
      TAP_A1:  operand = y1_q;
      TAP_A2:  operand = y2_q;
      default: operand = '0;
    endcase
    is_fb    = (tap == TAP_A1) || (tap == TAP_A2);
    coef_s   = coef;
    prod     = coef_s * operand;
    prod_ext = {{GUARD_W{prod[PROD_W-1]}}, prod};
    term     = is_fb ? -prod_ext : prod_ext;
    sum      = acc_q + term;
    sum_hi   = sum[ACC_W-1:COEF_FRAC];
    sum_lo   = sum[COEF_FRAC-1:0];
    if (sum_hi > HI_MAX) begin
      y_sat = HI_MAX[DATA_W-1:0];
    end else if (sum_hi < HI_MIN) begin
      y_sat = HI_MIN[DATA_W-1:0];
    end else begin
      y_sat = sum_hi[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      x0_q   <= '0;
      x1_q   <= '0;
      x2_q   <= '0;
      y1_q   <= '0;
      y2_q   <= '0;
      res_q  <= '0;
      yout_q <= '0;
    end else begin
      if (load_en) begin
        acc_q <= {{HI_W{1'b0}}, res_q};
        x0_q  <= in_data;
      end else if (mac_en) begin
        acc_q <= sum;
      end
      if (store_en) begin
        res_q  <= sum_lo;
        yout_q <= y_sat;
        y1_q   <= y_sat;
        y2_q   <= y1_q;
        x1_q   <= x0_q;
        x2_q   <= x1_q;
      end
    end
  end

  assign out_data = yout_q;

  // R6: a new sample starts from the carried residue alone, high part cleared
  assert_residue_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (acc_q[ACC_W-1:COEF_FRAC] == '0));

  // R7: an over-range high word saturates at the positive limit
  assert_clamp_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && (sum_hi > HI_MAX)) |=> (out_data == HI_MAX[DATA_W-1:0]));

  // R7: an under-range high word saturates at the negative limit
  assert_clamp_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && (sum_hi < HI_MIN)) |=> (out_data == HI_MIN[DATA_W-1:0]));

endmodule

// File: rtl/biquad_fs.sv
module biquad_fs
  import biquad_fs_pkg::*;
#(
  parameter int DATA_W    = 28,
  parameter int COEF_W    = 28,
  parameter int COEF_FRAC = 26,
  parameter int GUARD_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    out_data,
  input  logic                 coef_we,
  input  logic [TAP_SEL_W-1:0] coef_sel,
  input  logic [COEF_W-1:0]    coef_wdata
);

  logic              load_en, mac_en, store_en;
  tap_t              tap;
  logic [COEF_W-1:0] coef;
  logic              accept;

  biquad_fs_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .load_en  (load_en),
    .mac_en   (mac_en),
    .store_en (store_en),
    .tap      (tap)
  );

  biquad_fs_coef #(.COEF_W(COEF_W)) u_coef (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (coef_we),
    .wr_sel (coef_sel),
    .wr_data(coef_wdata),
    .rd_tap (tap),
    .rd_coef(coef)
  );

  biquad_fs_dp #(
    .DATA_W   (DATA_W),
    .COEF_W   (COEF_W),
    .COEF_FRAC(COEF_FRAC),
    .GUARD_W  (GUARD_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .mac_en  (mac_en),
    .store_en(store_en),
    .tap     (tap),
    .in_data (in_data),
    .coef    (coef),
    .out_data(out_data)
  );

  assign accept = in_valid && in_ready;

  // R2: once a sample is taken the input side closes
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R3: a result appears a fixed number of clocks after its sample was taken
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(accept, 6));

  // R4: a stalled result is held unchanged
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/tb_biquad_fs.sv
module tb_biquad_fs;

  localparam int  DW   = 28;
  localparam int  CW   = 28;
  localparam int  CF   = 26;
  localparam longint ONE  = 64'sd1 <<< CF;
  localparam longint YMAX = (64'sd1 <<< (DW-1)) - 1;
  localparam longint YMIN = -(64'sd1 <<< (DW-1));

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n;
  logic                 in_valid, in_ready, out_valid, out_ready;
  logic signed [DW-1:0] in_data, out_data;
  logic                 coef_we;
  logic [2:0]           coef_sel;
  logic [CW-1:0]        coef_wdata;

  biquad_fs dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_wdata(coef_wdata)
  );

  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;

  // reference model state
  longint mc [5];
  longint mx1, mx2, my1, my2, mres;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check_eq(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model_step(longint x);
    longint acc, hi;
    acc  = mres + mc[0]*x + mc[1]*mx1 + mc[2]*mx2 - mc[3]*my1 - mc[4]*my2;
    hi   = acc >>> CF;
    mres = acc - (hi <<< CF);
    if (hi > YMAX) hi = YMAX;
    if (hi < YMIN) hi = YMIN;
    mx2 = mx1; mx1 = x; my2 = my1; my1 = hi;
    return hi;
  endfunction

  function automatic longint rnd_range(longint half);
    return longint'($urandom_range(0, 32'(2*half - 1))) - half;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    coef_we = 1'b0; coef_sel = '0; coef_wdata = '0;
    for (int i = 0; i < 5; i++) mc[i] = 0;
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0; mres = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_coef(int sel, longint val);
    @(negedge clk);
    coef_we = 1'b1; coef_sel = 3'(sel); coef_wdata = val[CW-1:0];
    @(negedge clk);
    coef_we = 1'b0;
    if (sel < 5) mc[sel] = val;
  endtask

  // one sample with full handshake timing checks and optional stall
  task automatic run_sample(longint x, int hold, string req, output longint got);
    longint exp;
    exp = model_step(x);
    @(negedge clk);
    in_valid = 1'b1; in_data = x[DW-1:0]; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check_eq("R2 in_ready low after accept", longint'(in_ready), 0);
    repeat (4) @(negedge clk);
    check_eq("R3 out_valid still low", longint'(out_valid), 0);
    @(negedge clk);
    check_eq("R3 out_valid rises", longint'(out_valid), 1);
    got = longint'(out_data);
    check_eq(req, got, exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check_eq("R4 valid held", longint'(out_valid), 1);
      check_eq("R4 data held", longint'(out_data), exp);
      check_eq("R2 in_ready low while stalled", longint'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check_eq("R4 result taken", longint'(out_valid), 0);
    check_eq("R2 ready after take", longint'(in_ready), 1);
  endtask

  // continuous streaming with in_valid and out_ready held high
  task automatic stream(int n, longint half, string req);
    longint exp_q, last_acc;
    int     acc_cnt, got;
    bit     took;
    acc_cnt = 0; got = 0; last_acc = 0; exp_q = 0;
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1;
    in_data = DW'(rnd_range(half));
    while (got < n) begin
      took = 1'b0;
      if (out_valid) begin
        check_eq(req, longint'(out_data), exp_q);
        got++;
      end
      if (in_valid && in_ready) begin
        exp_q = model_step(longint'(in_data));
        if (acc_cnt > 0) check_eq("R3 sample spacing", cyc - last_acc, 6);
        last_acc = cyc;
        acc_cnt++;
        took = 1'b1;
      end
      @(negedge clk);
      if (took) begin
        if (acc_cnt >= n) in_valid = 1'b0;
        else in_data = DW'(rnd_range(half));
      end
    end
    out_ready = 1'b0; in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    longint limit = 150000;
    wait (cyc >= limit);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, limit);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint got;
    longint tail [10];
    void'($urandom(32'd4242));

    // R1 reset state
    do_reset();
    check_eq("R1 in_ready", longint'(in_ready), 1);
    check_eq("R1 out_valid", longint'(out_valid), 0);
    check_eq("R1 out_data", longint'(out_data), 0);
    run_sample(12345, 0, "R1 zero coefficients give zero", got);

    // R5 pass-through with random stalls
    write_coef(0, ONE);
    for (int i = 0; i < 6; i++) begin
      run_sample(rnd_range(64'sd1 <<< 26), int'($urandom_range(0, 3)), "R5 unity gain", got);
    end

    // R6 residue carry, exact values
    do_reset();
    write_coef(0, ONE/2);
    run_sample(1, 0, "R6 model", got);  check_eq("R6 first half", got, 0);
    run_sample(1, 1, "R6 model", got);  check_eq("R6 carried half", got, 1);
    run_sample(-1, 0, "R6 model", got); check_eq("R6 floor negative", got, -1);
    run_sample(-1, 2, "R6 model", got); check_eq("R6 residue cancels", got, 0);

    // R5 feedback sign: y = x + 0.5*y1
    do_reset();
    write_coef(0, ONE);
    write_coef(3, -ONE/2);
    run_sample(100, 0, "R5 model", got); check_eq("R5 fb step 0", got, 100);
    run_sample(0, 0, "R5 model", got);   check_eq("R5 fb step 1", got, 50);
    run_sample(0, 0, "R5 model", got);   check_eq("R5 fb step 2", got, 25);
    run_sample(0, 0, "R5 model", got);   check_eq("R5 fb step 3", got, 12);
    run_sample(0, 0, "R5 model", got);   check_eq("R5 fb step 4", got, 6);

    // R7 clamp both ways
    do_reset();
    write_coef(0, (64'sd1 <<< (CW-1)) - 1);
    run_sample(YMAX, 0, "R7 model", got); check_eq("R7 positive clamp", got, YMAX);
    run_sample(YMIN, 1, "R7 model", got); check_eq("R7 negative clamp", got, YMIN);

    // R8 zero input settles to exactly zero
    do_reset();
    write_coef(0, ONE);
    write_coef(3, -ONE/2);
    run_sample(-3, 0, "R8 model", got);
    for (int i = 0; i < 30; i++) begin
      run_sample(0, 0, "R8 model", got);
      if (i >= 20) tail[i-20] = got;
    end
    for (int i = 0; i < 10; i++) check_eq("R8 settled at zero", tail[i], 0);

    // R5/R3 full biquad streaming
    do_reset();
    write_coef(0, ONE/4);
    write_coef(1, ONE/2);
    write_coef(2, ONE/4);
    write_coef(3, -ONE);
    write_coef(4, ONE/2);
    stream(60, 64'sd1 <<< 20, "R5 biquad stream");

    // R9 unused select codes
    write_coef(5, rnd_range(64'sd1 <<< 27));
    write_coef(6, rnd_range(64'sd1 <<< 27));
    write_coef(7, rnd_range(64'sd1 <<< 27));
    run_sample(777, 0, "R9 unused selects ignored", got);
    stream(20, 64'sd1 <<< 20, "R9 stream after ignored writes");

    // R5 random feed-forward coefficients
    do_reset();
    for (int k = 0; k < 3; k++) write_coef(k, rnd_range(ONE));
    stream(40, 64'sd1 <<< 24, "R5 random taps");
    for (int i = 0; i < 4; i++) begin
      run_sample(rnd_range(64'sd1 <<< 24), int'($urandom_range(0, 4)), "R5 random taps stalled", got);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule